// File: doc/BRIEF.md
# CEC frame transmitter

This block sends one frame at a time on a single-wire, open-drain CEC bus. Software hands it transmit words through a one-deep holding register. Each word carries a data byte and four control flags. The engine waits until the bus has been free for long enough. It then sends a start bit, and for every byte it sends eight data bits (most significant first), an end-of-message bit and an acknowledge slot. All of these intervals are counted in ticks. A programmable prescaler derives the tick from the system clock, and every interval length is an input, so the block can be tuned to any clock rate.

The block never drives the line high. It asserts a drive-low enable and observes the real line level through a two-stage synchronizer. From that observed level it detects several conditions:
- another initiator winning the bus;
- a line held low for too long;
- a follower that did not acknowledge;
- software failing to supply the next byte in time.

Each of these is reported as its own one-cycle event. A completed frame raises a done event together with a NAK result.

Top module: `cec_frame_tx`

## Requirements
- R1: The start bit drives the line low for `t_start_lo` ticks, and the next bit begins `t_start_bit` ticks after the start bit's falling edge.
- R2: Every bit after the start bit lasts `t_bit` ticks.
  - A 0 is driven low for `t_lo0` ticks and a 1 for `t_lo1` ticks.
  - Data bits go out most significant bit first, followed by an end-of-message bit that is 1 only on the last byte.
  - The acknowledge slot is driven like a 1.
- R3: Before a start bit, the line must be observed high for N × `t_bit` consecutive ticks, counted from when the first word is accepted. N is 3 when the first word has the retry flag (bit 11). Otherwise N is 7 when the previous frame on the bus was this block's own completed frame, and 5 in all other cases.
- R4: The line is sampled `t_ack_smp` ticks into each acknowledge slot. In a direct frame, low means acknowledged. In a broadcast frame (flag bit 9), low means NAK. At the end of the frame, `nak` is 1 if any byte was not acknowledged.
- R5: A transmit word has the data byte in bits [7:0], end-of-message at bit 8, broadcast at bit 9, start-of-frame at bit 10 and retry at bit 11. A write is accepted only while `hold_full` is 0; a write while it is 1 is ignored. `ev_empty` pulses when a word without end-of-message moves into the shifter.
- R6: If the acknowledge slot of a byte without end-of-message ends and no word is waiting, `ev_underrun` pulses, the frame is aborted and the line is released.
- R7: If the line is read low while the block has released it (from `t_xition` ticks after the release point), outside the acknowledge slot, `ev_arb_lost` pulses and the frame is aborted.
- R8: After the start bit, if the line stays low for `t_err_lo` consecutive ticks, `ev_bus_err` pulses and the frame is aborted. This check takes priority over the arbitration check.
- R9: Deasserting `en` aborts any frame within one cycle: the line is released and the holding register is emptied.
- R10: A word without start-of-frame that arrives while the engine is idle is discarded without any bus activity.
- R11: After reset the line is released, the holding register is empty and no event is raised.
- R12: A frame that finishes its last acknowledge slot pulses `ev_done` exactly once and raises no other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; low aborts and clears |
| tick_div | input | 8 | A tick occurs every tick_div+1 clocks |
| t_start_lo | input | 8 | Start bit low time, ticks |
| t_start_bit | input | 8 | Start bit total length, ticks |
| t_lo0 | input | 8 | Low time of a 0 bit, ticks |
| t_lo1 | input | 8 | Low time of a 1 bit and of the acknowledge slot, ticks |
| t_bit | input | 8 | Data bit total length, ticks |
| t_ack_smp | input | 8 | Acknowledge sample point, ticks |
| t_xition | input | 8 | Allowance for the line to rise after release, ticks |
| t_err_lo | input | 8 | Low time that counts as a bus error, ticks |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_word | input | 12 | Transmit word (byte plus flags) |
| hold_full | output | 1 | Holding register occupied |
| line_in | input | 1 | Observed bus level (asynchronous) |
| drive_low | output | 1 | Open-drain pull-down enable |
| ev_empty | output | 1 | Pulse: ready for the next word |
| ev_underrun | output | 1 | Pulse: next word missing, frame aborted |
| ev_arb_lost | output | 1 | Pulse: arbitration lost, frame aborted |
| ev_bus_err | output | 1 | Pulse: line held low too long, frame aborted |
| ev_done | output | 1 | Pulse: frame completed |
| nak | output | 1 | NAK result, valid with ev_done |

## Verification
The bench decodes every drive-low pulse into a width and a period, so it would catch bits that are too short or too long, and inverted or byte-reversed data. It checks the bus-free gap for a first frame, a follow-on frame and a retry, which exposes a design that applies the wrong count of idle bit periods. It flips the acknowledge sense between direct and broadcast frames, so a block that ignores the broadcast flag reports the wrong `nak`. A colliding initiator, a follower stuck low, a missing second word, an `en` drop in mid-frame, a word written while full and a word without a start flag each target a specific failure: aborting on the wrong event, aborting late or not at all, or transmitting a word it should have discarded.

// File: rtl/cec_frame_tx.sv
module cec_frame_tx #(
  parameter int TW          = 8,
  parameter int IDLE_NEW    = 5,
  parameter int IDLE_FOLLOW = 7,
  parameter int IDLE_RETRY  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] tick_div,
  input  logic [TW-1:0] t_start_lo,
  input  logic [TW-1:0] t_start_bit,
  input  logic [TW-1:0] t_lo0,
  input  logic [TW-1:0] t_lo1,
  input  logic [TW-1:0] t_bit,
  input  logic [TW-1:0] t_ack_smp,
  input  logic [TW-1:0] t_xition,
  input  logic [TW-1:0] t_err_lo,
  input  logic          wr_en,
  input  logic [11:0]   wr_word,
  output logic          hold_full,
  input  logic          line_in,
  output logic          drive_low,
  output logic          ev_empty,
  output logic          ev_underrun,
  output logic          ev_arb_lost,
  output logic          ev_bus_err,
  output logic          ev_done,
  output logic          nak
);
  localparam int GW    = TW + 4;
  localparam int B_EOM = 8;
  localparam int B_BC  = 9;
  localparam int B_SOF = 10;
  localparam int B_RTY = 11;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_START, S_BITS} st_t;

  st_t           st;
  logic [TW-1:0] pc, cnt, low_run;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic          eom_q, bc_q, nak_acc, last_ours;
  logic [11:0]   hold;
  logic          hold_v;
  logic [GW-1:0] idle_cnt;
  logic [1:0]    ls;

  wire line_hi  = ls[1];
  wire tick     = (pc == tick_div);
  wire active   = (st == S_START) || (st == S_BITS);
  wire ack_slot = (st == S_BITS) && (bitn == 4'd9);
  wire bitval   = (bitn < 4'd8) ? sh[7] : ((bitn == 4'd8) ? eom_q : 1'b1);

  wire [TW-1:0] lo_t  = (st == S_START) ? t_start_lo : (bitval ? t_lo1 : t_lo0);
  wire [TW-1:0] dur_t = (st == S_START) ? t_start_bit : t_bit;
  wire          bit_end = (cnt == dur_t - TW'(1));

  wire released = active && !ack_slot &&
                  ({1'b0, cnt} >= ({1'b0, lo_t} + {1'b0, t_xition}));
  wire anom_hit = (st == S_BITS) && !line_hi &&
                  (({1'b0, low_run} + (TW+1)'(1)) >= {1'b0, t_err_lo});
  wire arb_hit  = released && !line_hi;
  wire smp_nak  = ack_slot && (cnt == t_ack_smp) && (bc_q ? !line_hi : line_hi);
  wire nak_next = nak_acc | smp_nak;

  wire [3:0]    nbits = hold[B_RTY] ? 4'(IDLE_RETRY) :
                        (last_ours ? 4'(IDLE_FOLLOW) : 4'(IDLE_NEW));
  wire [GW-1:0] need  = GW'(nbits) * GW'(t_bit);

  assign drive_low = active && (cnt < lo_t);
  assign hold_full = hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; cnt <= '0; low_run <= '0; bitn <= '0; sh <= '0;
      eom_q <= 1'b0; bc_q <= 1'b0; nak_acc <= 1'b0; last_ours <= 1'b0;
      hold <= '0; hold_v <= 1'b0; idle_cnt <= '0; ls <= 2'b11; nak <= 1'b0;
      ev_empty <= 1'b0; ev_underrun <= 1'b0; ev_arb_lost <= 1'b0;
      ev_bus_err <= 1'b0; ev_done <= 1'b0;
    end else begin
      ev_empty <= 1'b0; ev_underrun <= 1'b0; ev_arb_lost <= 1'b0;
      ev_bus_err <= 1'b0; ev_done <= 1'b0;
      pc <= tick ? '0 : pc + TW'(1);
      ls <= {ls[0], line_in};
      if (!en) begin
        st <= S_IDLE; hold_v <= 1'b0; last_ours <= 1'b0; cnt <= '0;
      end else begin
        if (wr_en && !hold_v) begin
          hold <= wr_word; hold_v <= 1'b1;
        end
        case (st)
          S_IDLE: begin
            if (tick && !line_hi) last_ours <= 1'b0;
            if (hold_v) begin
              if (hold[B_SOF]) begin st <= S_WAIT; idle_cnt <= '0; end
              else hold_v <= 1'b0;
            end
          end
          S_WAIT: if (tick) begin
            if (!line_hi) begin
              idle_cnt <= '0; last_ours <= 1'b0;
            end else if (idle_cnt + GW'(1) >= need) begin
              st <= S_START; cnt <= '0; nak_acc <= 1'b0; low_run <= '0;
            end else idle_cnt <= idle_cnt + GW'(1);
          end
          default: if (tick) begin
            low_run <= (st == S_START || line_hi) ? '0 :
                       ((&low_run) ? low_run : low_run + TW'(1));
            if (anom_hit || arb_hit) begin
              ev_bus_err <= anom_hit; ev_arb_lost <= !anom_hit;
              st <= S_IDLE; hold_v <= 1'b0; last_ours <= 1'b0; cnt <= '0;
            end else begin
              nak_acc <= nak_next;
              if (!bit_end) cnt <= cnt + TW'(1);
              else begin
                cnt <= '0;
                if (st == S_START || (ack_slot && !eom_q && hold_v)) begin
                  sh <= hold[7:0]; eom_q <= hold[B_EOM]; bc_q <= hold[B_BC];
                  hold_v <= 1'b0; ev_empty <= !hold[B_EOM];
                  bitn <= '0; st <= S_BITS;
                end else if (ack_slot && eom_q) begin
                  ev_done <= 1'b1; nak <= nak_next; st <= S_IDLE; last_ours <= 1'b1;
                end else if (ack_slot) begin
                  ev_underrun <= 1'b1; st <= S_IDLE; last_ours <= 1'b0;
                end else begin
                  bitn <= bitn + 4'd1;
                  if (bitn < 4'd8) sh <= {sh[6:0], 1'b0};
                end
              end
            end
          end
        endcase
      end
    end
  end

  // R9
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drive_low && !hold_full));

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_underrun || ev_arb_lost || ev_bus_err) |-> (!drive_low && !hold_full));

  // R5
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty |-> !hold_full);

  // R2
  tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> $stable(drive_low));

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_WAIT && st == S_START && t_start_lo != '0) |-> drive_low);

  // R12
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |-> (!ev_underrun && !ev_arb_lost && !ev_bus_err && !drive_low));
endmodule

// File: tb/cec_frame_tx_tb.sv
module cec_frame_tx_tb;
  localparam int DIV = 3, CK = DIV + 1;
  localparam int T_SLO = 8, T_SB = 11, T_LO0 = 5, T_LO1 = 2, T_BIT = 8;
  localparam int T_ACK = 3, T_XIT = 1, T_ERR = 12;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr_en = 1'b0;
  logic [11:0] wr_word = '0;
  logic hold_full, drive_low, ev_empty, ev_underrun, ev_arb_lost, ev_bus_err, ev_done, nak;

  int cyc = 0, ne = 0, fbase = 0, ack_mode = 0, col_arm = 0;
  int fol_cnt = 0, col_cnt = 0, wcyc = 0;
  int n_done = 0, n_arb = 0, n_anom = 0, n_und = 0, n_empty = 0;
  int stt [0:511];
  int lw  [0:511];
  logic pd = 1'b0;
  logic [7:0] fb [0:3];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  wire line_w = !(drive_low || (fol_cnt != 0) || (col_cnt != 0));

  always #10 clk = ~clk;

  cec_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick_div(8'(DIV)),
    .t_start_lo(8'(T_SLO)), .t_start_bit(8'(T_SB)), .t_lo0(8'(T_LO0)),
    .t_lo1(8'(T_LO1)), .t_bit(8'(T_BIT)), .t_ack_smp(8'(T_ACK)),
    .t_xition(8'(T_XIT)), .t_err_lo(8'(T_ERR)),
    .wr_en(wr_en), .wr_word(wr_word), .hold_full(hold_full),
    .line_in(line_w), .drive_low(drive_low),
    .ev_empty(ev_empty), .ev_underrun(ev_underrun), .ev_arb_lost(ev_arb_lost),
    .ev_bus_err(ev_bus_err), .ev_done(ev_done), .nak(nak));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pd <= drive_low;
    if (ev_done) n_done <= n_done + 1;
    if (ev_arb_lost) n_arb <= n_arb + 1;
    if (ev_bus_err) n_anom <= n_anom + 1;
    if (ev_underrun) n_und <= n_und + 1;
    if (ev_empty) n_empty <= n_empty + 1;
    if (ack_mode == 0) fol_cnt <= 0;
    else if (fol_cnt != 0) fol_cnt <= fol_cnt - 1;
    if (col_cnt != 0) col_cnt <= col_cnt - 1;
    if (drive_low && !pd && ne < 512) begin
      stt[ne] <= cyc;
      ne <= ne + 1;
      if (ne > fbase && (ne - fbase) % 10 == 0 && ack_mode != 0)
        fol_cnt <= (ack_mode == 2) ? 1000000 : T_LO0 * CK;
    end
    if (!drive_low && pd && ne > 0) lw[ne-1] <= cyc - stt[ne-1];
    if (col_arm != 0 && ne == fbase + 1 && cyc == stt[fbase] + 30) col_cnt <= 12;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] w);
    @(negedge clk);
    while (hold_full) @(negedge clk);
    wr_en = 1'b1; wr_word = w; wcyc = cyc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input int n, input bit bc, input bit rty, input int mode, input bit all);
    int e0, w0;
    ack_mode = mode; fbase = ne;
    e0 = n_done + n_arb + n_anom + n_und;
    for (int i = 0; i < n; i++) begin
      if (i == 0 || all) begin
        put({rty && i == 0, i == 0, bc, i == n - 1, fb[i]});
        if (i == 0) w0 = wcyc;
      end
    end
    wcyc = w0;
    for (int k = 0; k < 6000; k++) begin
      if (n_done + n_arb + n_anom + n_und != e0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(input int n, input int gap_bits, input string tg);
    int bad_t = 0, bad_d = 0, gap;
    int e = fbase;
    chk(ne - fbase == 1 + 10 * n, {tg, " R2 edge count"}, ne - fbase, 1 + 10 * n);
    if (lw[e] != T_SLO * CK || stt[e+1] - stt[e] != T_SB * CK) bad_t++;
    chk(bad_t == 0, {tg, " R1 start bit"}, lw[e], T_SLO * CK);
    for (int b = 0; b < n; b++)
      for (int j = 0; j < 10; j++) begin
        int idx = e + 1 + 10 * b + j;
        bit v = (j < 8) ? fb[b][7-j] : ((j == 8) ? (b == n - 1) : 1'b1);
        if (lw[idx] != (v ? T_LO1 : T_LO0) * CK) bad_d++;
        if (idx + 1 < ne && stt[idx+1] - stt[idx] != T_BIT * CK) bad_d++;
      end
    chk(bad_d == 0, {tg, " R2 data bits"}, bad_d, 0);
    if (gap_bits != 0) begin
      gap = stt[e] - wcyc;
      chk(gap >= gap_bits * T_BIT * CK && gap <= gap_bits * T_BIT * CK + 8,
          {tg, " R3 idle gap"}, gap, gap_bits * T_BIT * CK);
    end
  endtask

  initial begin
    int d0, a0, m0, u0, p0, e1;
    repeat (3) @(negedge clk);
    chk(!drive_low && !hold_full, "R11 reset outputs", int'(drive_low) + int'(hold_full), 0);
    chk(!ev_done && !ev_empty && !ev_underrun && !ev_arb_lost && !ev_bus_err,
        "R11 reset events", int'(ev_done), 0);
    rst_n = 1'b1; en = 1'b1;
    repeat (5) @(negedge clk);

    fb[0] = 8'h40; fb[1] = 8'hA5;
    d0 = n_done; p0 = n_empty;
    send(2, 0, 0, 1, 1);
    check_frame(2, 5, "T1");
    chk(n_done - d0 == 1, "R12 done once", n_done - d0, 1);
    chk(nak == 0, "R4 direct acked", nak, 0);
    chk(n_empty - p0 == 1, "R5 empty events", n_empty - p0, 1);

    fb[0] = 8'h4F;
    ack_mode = 1; fbase = ne;
    put({1'b0, 1'b1, 1'b0, 1'b1, 8'h4F}); e1 = wcyc;
    @(negedge clk); wr_en = 1'b1; wr_word = {4'b0101, 8'h3C};
    @(negedge clk); wr_en = 1'b0;
    d0 = n_done;
    for (int k = 0; k < 3000 && n_done == d0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    wcyc = e1;
    check_frame(1, 7, "T2 R5 write-when-full");
    chk(n_arb + n_anom + n_und == 0, "R12 no abort events", n_arb + n_anom + n_und, 0);

    fb[0] = 8'h41;
    send(1, 0, 0, 0, 1);
    check_frame(1, 7, "T3");
    chk(nak == 1, "R4 direct unacked", nak, 1);

    fb[0] = 8'h4F; fb[1] = 8'h36;
    send(2, 1, 0, 0, 1);
    check_frame(2, 0, "T4");
    chk(nak == 0, "R4 broadcast unopposed", nak, 0);
    send(2, 1, 0, 1, 1);
    chk(nak == 1, "R4 broadcast pulled low", nak, 1);

    fb[0] = 8'h12;
    send(1, 0, 1, 1, 1);
    check_frame(1, 3, "T5 retry");

    p0 = ne;
    put({4'b0001, 8'h77});
    repeat (3) @(negedge clk);
    chk(!hold_full, "R10 word dropped", hold_full, 0);
    repeat (400) @(negedge clk);
    chk(ne == p0, "R10 no bus activity", ne - p0, 0);

    fb[0] = 8'h40; fb[1] = 8'h55;
    u0 = n_und; d0 = n_done;
    send(2, 0, 0, 1, 0);
    chk(n_und - u0 == 1, "R6 underrun event", n_und - u0, 1);
    chk(n_done == d0 && ne - fbase == 11, "R6 frame aborted", ne - fbase, 11);
    chk(!drive_low, "R6 line released", drive_low, 0);

    fb[0] = 8'h40;
    a0 = n_arb; d0 = n_done; col_arm = 1;
    send(1, 0, 0, 1, 1);
    col_arm = 0;
    chk(n_arb - a0 == 1, "R7 arbitration lost", n_arb - a0, 1);
    chk(n_done == d0 && ne - fbase == 1, "R7 no further bits", ne - fbase, 1);
    chk(!drive_low && !hold_full, "R7 released", drive_low, 0);

    fb[0] = 8'h40; fb[1] = 8'h10;
    m0 = n_anom; a0 = n_arb; d0 = n_done;
    send(2, 0, 0, 2, 1);
    chk(n_anom - m0 == 1, "R8 bus error event", n_anom - m0, 1);
    chk(n_arb == a0 && n_done == d0, "R8 priority over arbitration", n_arb - a0, 0);
    chk(ne - fbase == 12, "R8 aborted in next byte", ne - fbase, 12);
    ack_mode = 0;
    repeat (20) @(negedge clk);

    fb[0] = 8'h40; fb[1] = 8'h99;
    ack_mode = 1; fbase = ne; d0 = n_done; u0 = n_und;
    put({4'b0100, 8'h40});
    put({4'b0001, 8'h99});
    while (ne - fbase < 3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!drive_low && !hold_full, "R9 disable aborts", int'(drive_low) + int'(hold_full), 0);
    p0 = ne;
    repeat (300) @(negedge clk);
    chk(ne == p0 && n_done == d0 && n_und == u0, "R9 stays quiet", ne - p0, 0);
    en = 1'b1;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule